// File: doc/BRIEF.md
# Timing Reference Mode Controller

This block picks the timing reference for a T1/E1 line interface. A four-bit mode code from a control register selects the reference. The choices are the backplane clock/frame pulse, the free-running local oscillator, one of the recovered receive clocks (chosen by an index), or the external sync input. A separate code requests a manual holdover. The whole block runs on the local-oscillator clock. A mode write takes effect on the next edge of that clock.

In the line-sync and external-sync modes the block watches an activity signal from the selected reference. If that signal stops toggling, the block drops into automatic holdover and freezes the reference index. It returns to the requested sync mode once the reference has toggled steadily for a set number of periods. The block also drives two controls from the mode, the E1/T1 select and the remote-loopback flag. One is the enable for the transmit jitter attenuator. The other is the bypass for the backplane jitter filter. The phase-locked loop and the analog clock multiplexing are outside this block.

Top module: `tref_ctrl`

## Requirements
- R1: After reset the block is in free-run. `mode_o`=1, `ref_sel`=1, `holdover_o`=0 and `bp_bypass`=0.
- R2: The code `mode_code`={MS2,MS1,BUSM,ESYNI}, with bit 3 first, decodes as follows: 000x is bus sync, 101x is free-run, 0010 is line sync, 0011 is external sync and 011x is a holdover request. The new mode shows on `mode_o` one clock after the code is applied. The encoding of `mode_o` is 0 bus sync, 1 free-run, 2 line sync, 3 external sync, 4 auto-holdover and 5 holdover.
- R3: The codes 100x and 11xx are undefined and leave the current mode unchanged.
- R4: `ref_sel` encodes the reference: 0 backplane, 1 local oscillator, 2+`line_idx` a receive clock, and 6 the external sync. Free-run always selects 1 and nothing else. In line sync, a change of `line_idx` moves `ref_sel` one clock later.
- R5: A holdover request is ignored unless the current mode is line sync, external sync or auto-holdover.
- R6: In holdover `holdover_o`=1 and `ref_sel` stays at the last sync reference, even when `line_idx` changes. Writing any other valid code leaves holdover.
- R7: In line or external sync, 256 consecutive clocks with no edge on the selected activity input move the block to auto-holdover. It then drives `holdover_o`=1 and keeps `ref_sel` unchanged. Activity on unselected inputs has no effect.
- R8: In auto-holdover, 16 consecutive good periods of the frozen reference return the block to the sync mode it left, and `holdover_o` goes to 0. A good period runs between rising edges with no loss in between.
- R9: `ja_en`=1 when `rlbk` is high, or in bus sync with `is_e1` high. Otherwise it is 0.
- R10: `bp_bypass`=1 in bus sync only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local-oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_code | input | 4 | Mode field {MS2,MS1,BUSM,ESYNI} |
| line_idx | input | 2 | Receive-clock index for line sync |
| is_e1 | input | 1 | 1 = E1 framing, 0 = T1 |
| rlbk | input | 1 | Remote loopback active |
| rx_act | input | 4 | Activity toggles of the recovered receive clocks |
| esyn_act | input | 1 | Activity toggle of the external sync |
| mode_o | output | 3 | Current timing mode |
| ref_sel | output | 3 | Selected reference index |
| holdover_o | output | 1 | Registered holdover flag |
| ja_en | output | 1 | Jitter attenuator enable |
| bp_bypass | output | 1 | Backplane jitter filter bypass |

## Verification
The assertions assume a few things about the inputs. The activity inputs are slow toggles, so each level lasts well over the two synchronizer stages. The mode code stays valid for at least one clock. Reset is held for several clocks at start-up. The stimulus toggles every activity input once every eight clocks from a single generator and stops only the input under test. Code and index changes are applied one clock after an edge, so every transition the properties check comes from a settled register value.

// File: rtl/tref_pkg.sv
// Package: types shared by the timing reference controller.
// Assumes: mode encoding below is visible at the top-level mode output.
package tref_pkg;

    localparam int CODE_W = 4;

    typedef enum logic [2:0] {
        TM_BUS    = 3'd0,
        TM_FREE   = 3'd1,
        TM_LINE   = 3'd2,
        TM_EXT    = 3'd3,
        TM_AUTOHO = 3'd4,
        TM_HOLD   = 3'd5
    } tmode_e;

endpackage

// File: rtl/tref_code_decode.sv
// Module: turns the register mode field into a requested mode.
// Assumes: code bit order {MS2,MS1,BUSM,ESYNI}; undefined codes flag invalid.
module tref_code_decode
    import tref_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic              valid,
    output tmode_e            req_mode
);

    // purpose: map each defined code pattern to a mode
    always_comb begin
        valid    = 1'b1;
        req_mode = TM_FREE;
        casez (code)
            4'b000?: req_mode = TM_BUS;
            4'b101?: req_mode = TM_FREE;
            4'b0010: req_mode = TM_LINE;
            4'b0011: req_mode = TM_EXT;
            4'b011?: req_mode = TM_HOLD;
            default: valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/tref_act_sync.sv
// Module: brings asynchronous activity toggles into the oscillator domain.
// Assumes: each input level lasts several clocks; STAGES >= 2.
module tref_act_sync #(
    parameter int N      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] act_in,
    output logic [N-1:0] act_cur,
    output logic [N-1:0] act_prev
);

    for (genvar gi = 0; gi < N; gi++) begin : g_chain
        logic [STAGES:0] sh_q;

        // purpose: shift the raw toggle through the synchronizer and one delay
        always_ff @(posedge clk) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[STAGES-1:0], act_in[gi]};
        end

        assign act_cur[gi]  = sh_q[STAGES-1];
        assign act_prev[gi] = sh_q[STAGES];
    end

endmodule

// File: rtl/tref_ref_monitor.sv
// Module: watches the selected reference for loss and for recovery.
// Assumes: idx selects one of N synchronized toggles; in_ho marks auto-holdover.
module tref_ref_monitor #(
    parameter int N        = 5,
    parameter int IDX_W    = 3,
    parameter int LOSS_LIM = 256,
    parameter int GOOD_LIM = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             in_ho,
    input  logic [IDX_W-1:0] idx,
    input  logic [N-1:0]     act_cur,
    input  logic [N-1:0]     act_prev,
    output logic             loss,
    output logic             recovered
);

    localparam int QW = $clog2(LOSS_LIM + 1);
    localparam int GW = $clog2(GOOD_LIM + 1);

    logic [QW-1:0]    quiet_q;
    logic [GW-1:0]    good_q;
    logic [IDX_W-1:0] idx_q;
    logic             idx_chg;
    logic             sel_cur;
    logic             sel_prev;
    logic             sel_edge;
    logic             sel_rise;

    // purpose: pick the monitored toggle and find its edges
    always_comb begin
        sel_cur  = act_cur[idx];
        sel_prev = act_prev[idx];
        sel_edge = sel_cur ^ sel_prev;
        sel_rise = sel_cur & ~sel_prev;
        idx_chg  = (idx != idx_q);
    end

    // purpose: remember the index to spot a switch of reference
    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx;
    end

    // purpose: count quiet clocks since the last edge, saturating at the limit
    always_ff @(posedge clk) begin
        if (!rst_n)                          quiet_q <= '0;
        else if (!run || idx_chg || sel_edge) quiet_q <= '0;
        else if (quiet_q != QW'(LOSS_LIM))   quiet_q <= quiet_q + 1'b1;
    end

    assign loss = run && !idx_chg && (quiet_q == QW'(LOSS_LIM));

    // purpose: count good periods while in auto-holdover
    always_ff @(posedge clk) begin
        if (!rst_n)                                     good_q <= '0;
        else if (!in_ho || loss)                        good_q <= '0;
        else if (sel_rise && good_q != GW'(GOOD_LIM-1)) good_q <= good_q + 1'b1;
    end

    assign recovered = in_ho && !loss && sel_rise && (good_q == GW'(GOOD_LIM-1));

    // R7: loss only appears after a clock with no edge on the selected toggle
    p_loss_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loss) |-> $past(!sel_edge));

    // R8: the good-period count never exceeds its terminal value
    p_good_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        good_q < GW'(GOOD_LIM));

endmodule

// File: rtl/tref_mode_fsm.sv
// Module: holds the current timing mode, the frozen reference and the flag.
// Assumes: requested mode decoded upstream; loss/recovered from the monitor.
module tref_mode_fsm
    import tref_pkg::*;
#(
    parameter int NRX   = 4,
    parameter int LIDX_W = 2,
    parameter int MON_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_valid,
    input  tmode_e            dec_mode,
    input  logic [LIDX_W-1:0] line_idx,
    input  logic              loss,
    input  logic              recovered,
    output tmode_e            mode_q,
    output logic [MON_W-1:0]  ref_q,
    output logic              hold_q
);

    tmode_e nxt;
    tmode_e sync_q;
    logic   in_sync;

    assign in_sync = (mode_q == TM_LINE) || (mode_q == TM_EXT);

    // purpose: next-mode rules for requests, loss and recovery
    always_comb begin
        nxt = mode_q;
        if (dec_valid) begin
            case (dec_mode)
                TM_BUS, TM_FREE: nxt = dec_mode;
                TM_HOLD: begin
                    if (in_sync || mode_q == TM_AUTOHO) nxt = TM_HOLD;
                end
                TM_LINE, TM_EXT: begin
                    if (!(mode_q == TM_AUTOHO && dec_mode == sync_q)) nxt = dec_mode;
                end
                default: nxt = mode_q;
            endcase
        end
        if (in_sync && nxt == mode_q && loss) nxt = TM_AUTOHO;
        if (mode_q == TM_AUTOHO && nxt == TM_AUTOHO && recovered) nxt = sync_q;
    end

    // purpose: register mode, last sync mode and the holdover flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= TM_FREE;
            sync_q <= TM_LINE;
            hold_q <= 1'b0;
        end else begin
            mode_q <= nxt;
            if (nxt == TM_LINE || nxt == TM_EXT) sync_q <= nxt;
            hold_q <= (nxt == TM_AUTOHO) || (nxt == TM_HOLD);
        end
    end

    // purpose: load the monitored index in sync modes, freeze it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)              ref_q <= '0;
        else if (nxt == TM_LINE) ref_q <= MON_W'(line_idx);
        else if (nxt == TM_EXT)  ref_q <= MON_W'(NRX);
    end

    // R5: manual holdover is entered only from a sync mode or auto-holdover
    p_hold_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == TM_HOLD && $past(mode_q) != TM_HOLD) |->
        ($past(mode_q) == TM_LINE || $past(mode_q) == TM_EXT || $past(mode_q) == TM_AUTOHO));

    // R7: auto-holdover is entered only from line or external sync
    p_autoho_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == TM_AUTOHO && $past(mode_q) != TM_AUTOHO) |->
        ($past(mode_q) == TM_LINE || $past(mode_q) == TM_EXT));

    // R6: the registered flag agrees with the registered mode
    p_ho_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q == (mode_q == TM_AUTOHO || mode_q == TM_HOLD));

    // R6: the reference stays frozen while holdover persists
    p_ref_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == TM_HOLD && $past(mode_q) == TM_HOLD) |-> $stable(ref_q));

endmodule

// File: rtl/tref_ctrl.sv
// Module: top of the timing reference mode controller.
// Assumes: clk is the local oscillator; activity inputs are asynchronous toggles.
module tref_ctrl
    import tref_pkg::*;
#(
    parameter int NRX      = 4,
    parameter int LOSS_LIM = 256,
    parameter int GOOD_LIM = 16,
    parameter int STAGES   = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CODE_W-1:0]       mode_code,
    input  logic [$clog2(NRX)-1:0]  line_idx,
    input  logic                    is_e1,
    input  logic                    rlbk,
    input  logic [NRX-1:0]          rx_act,
    input  logic                    esyn_act,
    output logic [2:0]              mode_o,
    output logic [$clog2(NRX+3)-1:0] ref_sel,
    output logic                    holdover_o,
    output logic                    ja_en,
    output logic                    bp_bypass
);

    localparam int LIDX_W = $clog2(NRX);
    localparam int NMON   = NRX + 1;
    localparam int MON_W  = $clog2(NMON);
    localparam int REF_W  = $clog2(NRX + 3);

    logic             dec_valid;
    tmode_e           dec_mode;
    tmode_e           mode_q;
    logic [MON_W-1:0] ref_q;
    logic [NMON-1:0]  act_cur;
    logic [NMON-1:0]  act_prev;
    logic             loss;
    logic             recovered;
    logic             mon_run;

    tref_code_decode u_dec (
        .code     (mode_code),
        .valid    (dec_valid),
        .req_mode (dec_mode)
    );

    tref_act_sync #(.N(NMON), .STAGES(STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_in   ({esyn_act, rx_act}),
        .act_cur  (act_cur),
        .act_prev (act_prev)
    );

    assign mon_run = (mode_q == TM_LINE) || (mode_q == TM_EXT) || (mode_q == TM_AUTOHO);

    tref_ref_monitor #(
        .N        (NMON),
        .IDX_W    (MON_W),
        .LOSS_LIM (LOSS_LIM),
        .GOOD_LIM (GOOD_LIM)
    ) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (mon_run),
        .in_ho     (mode_q == TM_AUTOHO),
        .idx       (ref_q),
        .act_cur   (act_cur),
        .act_prev  (act_prev),
        .loss      (loss),
        .recovered (recovered)
    );

    tref_mode_fsm #(.NRX(NRX), .LIDX_W(LIDX_W), .MON_W(MON_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .dec_valid (dec_valid),
        .dec_mode  (dec_mode),
        .line_idx  (line_idx),
        .loss      (loss),
        .recovered (recovered),
        .mode_q    (mode_q),
        .ref_q     (ref_q),
        .hold_q    (holdover_o)
    );

    // purpose: translate mode and frozen index into the reference selector
    always_comb begin
        case (mode_q)
            TM_BUS:  ref_sel = '0;
            TM_FREE: ref_sel = REF_W'(1);
            default: ref_sel = (ref_q == MON_W'(NRX)) ? REF_W'(NRX + 2)
                                                       : REF_W'(ref_q) + REF_W'(2);
        endcase
    end

    // purpose: jitter attenuator and backplane filter controls from the mode
    always_comb begin
        mode_o    = mode_q;
        bp_bypass = (mode_q == TM_BUS);
        ja_en     = rlbk || ((mode_q == TM_BUS) && is_e1);
    end

    // R4: free-run always selects the local oscillator
    p_free_osc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd1) |-> (ref_sel == REF_W'(1)));

    // R10: the filter bypass never coexists with a non-bus mode
    p_bypass_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bp_bypass |-> (mode_o == 3'd0));

    // R9: E1 bus sync always has the attenuator enabled
    p_ja_e1_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd0 && is_e1) |-> ja_en);

endmodule

// File: tb/tref_ctrl_tb_top.sv
`timescale 1ns/1ps
module tref_ctrl_tb_top;

    typedef struct packed {
        logic [7:0] req;
        logic [2:0] mode;
        logic [2:0] rsel;
        logic       ho;
        logic       ja;
        logic       byp;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] mode_code = 4'b1010;
    logic [1:0] line_idx = 2'd0;
    logic       is_e1 = 1'b0;
    logic       rlbk = 1'b0;
    logic [4:0] act = '0;
    logic [4:0] act_en = 5'b11111;
    logic [2:0] mode_o;
    logic [2:0] ref_sel;
    logic       holdover_o;
    logic       ja_en;
    logic       bp_bypass;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    tref_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_code  (mode_code),
        .line_idx   (line_idx),
        .is_e1      (is_e1),
        .rlbk       (rlbk),
        .rx_act     (act[3:0]),
        .esyn_act   (act[4]),
        .mode_o     (mode_o),
        .ref_sel    (ref_sel),
        .holdover_o (holdover_o),
        .ja_en      (ja_en),
        .bp_bypass  (bp_bypass)
    );

    // activity generator: enabled sources toggle every 8 clocks
    initial begin
        forever begin
            repeat (8) @(posedge clk);
            #1 act = act ^ act_en;
        end
    end

    // monitor: pop one expectation per falling edge and compare
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_cmp++;
                if (mode_o !== e.mode || ref_sel !== e.rsel || holdover_o !== e.ho ||
                    ja_en !== e.ja || bp_bypass !== e.byp) begin
                    n_bad++;
                    $display("FAIL R%0d: got mode=%0d ref=%0d ho=%0b ja=%0b byp=%0b, expected mode=%0d ref=%0d ho=%0b ja=%0b byp=%0b",
                             e.req, mode_o, ref_sel, holdover_o, ja_en, bp_bypass,
                             e.mode, e.rsel, e.ho, e.ja, e.byp);
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input int req, input int m, input int r, input bit ho,
                       input bit ja, input bit byp);
        exp_t e;
        e.req = 8'(req); e.mode = 3'(m); e.rsel = 3'(r);
        e.ho = ho; e.ja = ja; e.byp = byp;
        exp_q.push_back(e);
        @(negedge clk);
        #1;
    endtask

    task automatic setc(input logic [3:0] c);
        step(1);
        mode_code = c;
        step(1);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // driver
    initial begin
        step(5);
        rst_n = 1'b1;
        step(1);
        chk(1, 1, 1, 0, 0, 0);                // R1 reset state

        is_e1 = 1'b1;
        setc(4'b0000); chk(2, 0, 0, 0, 1, 1);  // R2 R9 R10 E1 bus sync
        is_e1 = 1'b0;
        setc(4'b0001); chk(9, 0, 0, 0, 0, 1);  // R9 T1 bus sync, no loopback
        rlbk = 1'b1;
        step(1);       chk(9, 0, 0, 0, 1, 1);  // R9 loopback forces enable
        rlbk = 1'b0;
        setc(4'b0110); chk(5, 0, 0, 0, 0, 1);  // R5 hold request from bus ignored
        setc(4'b1000); chk(3, 0, 0, 0, 0, 1);  // R3 undefined 100x
        setc(4'b1101); chk(3, 0, 0, 0, 0, 1);  // R3 undefined 11xx
        setc(4'b1011); chk(4, 1, 1, 0, 0, 0);  // R4 free-run uses oscillator
        setc(4'b0111); chk(5, 1, 1, 0, 0, 0);  // R5 hold request from free-run ignored

        line_idx = 2'd2;
        setc(4'b0010); chk(4, 2, 4, 0, 0, 0);  // R4 R10 line sync idx 2
        line_idx = 2'd1;
        step(1);       chk(4, 2, 3, 0, 0, 0);  // R4 index change follows
        rlbk = 1'b1;
        setc(4'b0111); chk(6, 5, 3, 1, 1, 0);  // R6 holdover from line
        rlbk = 1'b0;
        line_idx = 2'd0;
        step(2);       chk(6, 5, 3, 1, 0, 0);  // R6 index frozen in holdover
        setc(4'b0010); chk(6, 2, 2, 0, 0, 0);  // R6 leave holdover

        act_en = 5'b11110;                     // R7 stop rx0, others keep going
        step(200);     chk(7, 2, 2, 0, 0, 0);  // R7 not yet lost
        step(100);     chk(7, 4, 2, 1, 0, 0);  // R7 auto-holdover
        act_en = 5'b11111;
        step(224);     chk(8, 4, 2, 1, 0, 0);  // R8 too few good periods
        step(96);      chk(8, 2, 2, 0, 0, 0);  // R8 recovered to line sync

        setc(4'b0011); chk(4, 3, 6, 0, 0, 0);  // R4 external sync
        act_en = 5'b01111;
        step(300);     chk(7, 4, 6, 1, 0, 0);  // R7 ext loss
        setc(4'b0110); chk(5, 5, 6, 1, 0, 0);  // R5 hold from auto-holdover
        is_e1 = 1'b1;
        setc(4'b0000); chk(2, 0, 0, 0, 1, 1);  // R2 bus sync again

        wait (exp_q.size() == 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule